// File: doc/BRIEF.md
# Instruction Reuse Classification Table

This block keeps a learned estimate, for each load or store instruction, of how often that instruction touches data it has already used. The estimate lives in a table of saturating counters. The table is addressed by a short hash of the instruction's program counter. A training port reports events, and each event is either a reuse (the data was touched before) or a first touch. A reuse moves the selected counter up and a first touch moves it down. The counter stops at either end of its range.

A query port takes a program counter and returns the current counter value one cycle later. The value comes together with a five-level class, ordered from the least reused to the most reused: bypass candidate, useless, normal, useful and strong reuse. The consumer uses the class to decide where a new line is placed, or whether it is placed at all.

Both ports use valid/ready handshakes. The training port never applies back-pressure. The query port has a single response register. A query is taken only when that register is empty, or when the register is being emptied in the same cycle. A response waits, unchanged, until the consumer raises `rsp_ready`.

Top module: `reuse_class_table`

## Requirements
- R1: After reset every counter holds 128, `rsp_valid` is low, and `qry_ready` and `trn_ready` are high.
- R2: A training event with `trn_reuse`=1 raises the indexed counter by one, except that a counter at 255 stays at 255.
- R3: A training event with `trn_reuse`=0 (first touch) lowers the indexed counter by one, except that a counter at 0 stays at 0.
- R4: `rsp_class` encodes the returned counter value as follows: below 32 gives 0 (bypass), below 96 gives 1 (useless), below 160 gives 2 (normal), below 224 gives 3 (useful), and anything higher gives 4 (strong reuse).
- R5: The table index is PC bits [10:2] XOR PC bits [19:11]. Two PCs that produce the same index share one counter.
- R6: A query is accepted on a clock edge where `qry_valid` and `qry_ready` are both high. After that edge `rsp_valid` is high, and `rsp_cnt` and `rsp_class` hold the indexed counter as it stood before the edge.
- R7: `qry_ready` equals NOT `rsp_valid` OR `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the response stays unchanged.
- R8: When a query and a training event address the same index in the same cycle, the response carries the counter value from before that training event.
- R9: `trn_ready` is always high. Training takes effect whatever the state of the query and response handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trn_valid | input | 1 | Training event present |
| trn_ready | output | 1 | Training accepted (always high) |
| trn_pc | input | 32 | PC of the instruction being trained |
| trn_reuse | input | 1 | 1 = data reuse, 0 = first touch |
| qry_valid | input | 1 | Query present |
| qry_ready | output | 1 | Query can be accepted |
| qry_pc | input | 32 | PC to classify |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_cnt | output | 8 | Counter value returned |
| rsp_class | output | 3 | Reuse class, 0 to 4 |

## Verification
The assertions take two things for granted about the inputs. The first is that `rsp_ready` may change in any cycle, so a response can be held for a long time. The second is that query inputs are sampled only when a handshake completes, and may change freely while `qry_ready` is low. The stimulus drives random `rsp_ready` and random query and training valids. It uses a small pool of PCs, aliasing pairs among them, so that counters reach both saturation limits. It never holds inputs in ways that the handshake rules forbid. Directed runs step a single counter through every class boundary. In those runs the query and the training event share one PC in the same cycle.

// File: rtl/rct_pkg.sv
package rct_pkg;
  typedef enum logic [2:0] {
    RC_BYPASS  = 3'd0,
    RC_USELESS = 3'd1,
    RC_NORMAL  = 3'd2,
    RC_USEFUL  = 3'd3,
    RC_REUSE   = 3'd4
  } reuse_class_e;
endpackage

// File: rtl/rct_index_hash.sv
module rct_index_hash #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 9,
  parameter int LSB   = 2
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  localparam int HI_BASE = LSB + IDX_W;
  // fold two adjacent slices of the PC above the byte offset
  assign idx = pc[LSB +: IDX_W] ^ pc[HI_BASE +: IDX_W];
endmodule

// File: rtl/rct_classifier.sv
module rct_classifier
  import rct_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt,
  output reuse_class_e     cls
);
  localparam int SPAN = 1 << CNT_W;
  localparam int TH_USELESS = SPAN / 8;
  localparam int TH_NORMAL  = (SPAN * 3) / 8;
  localparam int TH_USEFUL  = (SPAN * 5) / 8;
  localparam int TH_REUSE   = (SPAN * 7) / 8;

  always_comb begin
    if (int'(cnt) < TH_USELESS)     cls = RC_BYPASS;
    else if (int'(cnt) < TH_NORMAL) cls = RC_USELESS;
    else if (int'(cnt) < TH_USEFUL) cls = RC_NORMAL;
    else if (int'(cnt) < TH_REUSE)  cls = RC_USEFUL;
    else                            cls = RC_REUSE;
  end
endmodule

// File: rtl/rct_counter_bank.sv
module rct_counter_bank #(
  parameter int IDX_W = 9,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_cnt
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_MIN  = '0;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(1 << (CNT_W - 1));

  logic [CNT_W-1:0] ctr_q [DEPTH];
  logic [CNT_W-1:0] cur;
  logic [CNT_W-1:0] nxt;

  assign cur = ctr_q[wr_idx];

  always_comb begin
    nxt = cur;
    if (wr_up) begin
      if (cur != CNT_MAX) nxt = cur + 1'b1;
    end else begin
      if (cur != CNT_MIN) nxt = cur - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CNT_INIT;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= nxt;
    end
  end

  // read sees the stored value, i.e. before any write at this edge
  assign rd_cnt = ctr_q[rd_idx];
endmodule

// File: rtl/reuse_class_table.sv
module reuse_class_table
  import rct_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 9,
  parameter int CNT_W = 8,
  parameter int LSB   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trn_valid,
  output logic             trn_ready,
  input  logic [PC_W-1:0]  trn_pc,
  input  logic             trn_reuse,
  input  logic             qry_valid,
  output logic             qry_ready,
  input  logic [PC_W-1:0]  qry_pc,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [CNT_W-1:0] rsp_cnt,
  output logic [2:0]       rsp_class
);
  logic [IDX_W-1:0] t_idx;
  logic [IDX_W-1:0] q_idx;
  logic [CNT_W-1:0] q_cnt;
  reuse_class_e     q_cls;
  logic             q_take;

  logic             rv_q;
  logic [CNT_W-1:0] rc_q;
  reuse_class_e     rk_q;

  rct_index_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .LSB(LSB)) u_hash_t (
    .pc(trn_pc), .idx(t_idx)
  );
  rct_index_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .LSB(LSB)) u_hash_q (
    .pc(qry_pc), .idx(q_idx)
  );

  rct_counter_bank #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(trn_valid), .wr_idx(t_idx), .wr_up(trn_reuse),
    .rd_idx(q_idx), .rd_cnt(q_cnt)
  );

  rct_classifier #(.CNT_W(CNT_W)) u_cls (.cnt(q_cnt), .cls(q_cls));

  assign trn_ready = 1'b1;
  assign qry_ready = !rv_q || rsp_ready;
  assign q_take    = qry_valid && qry_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rc_q <= '0;
      rk_q <= RC_BYPASS;
    end else if (q_take) begin
      rv_q <= 1'b1;
      rc_q <= q_cnt;
      rk_q <= q_cls;
    end else if (rsp_ready) begin
      rv_q <= 1'b0;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_cnt   = rc_q;
  assign rsp_class = rk_q;
endmodule

// File: rtl/rct_chk.sv
module rct_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             qry_valid,
  input logic             qry_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [CNT_W-1:0] rsp_cnt,
  input logic [2:0]       rsp_class
);
  localparam int SPAN = 1 << CNT_W;

  // R4
  class_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((int'(rsp_cnt) < SPAN/8)       ? rsp_class == 3'd0 :
                   (int'(rsp_cnt) < (SPAN*3)/8)   ? rsp_class == 3'd1 :
                   (int'(rsp_cnt) < (SPAN*5)/8)   ? rsp_class == 3'd2 :
                   (int'(rsp_cnt) < (SPAN*7)/8)   ? rsp_class == 3'd3 :
                                                    rsp_class == 3'd4));

  // R6
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qry_valid && qry_ready |=> rsp_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_cnt) && $stable(rsp_class));

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !qry_ready);
endmodule

bind reuse_class_table rct_chk #(.CNT_W(CNT_W)) u_rct_chk (
  .clk(clk), .rst_n(rst_n), .qry_valid(qry_valid), .qry_ready(qry_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_cnt(rsp_cnt),
  .rsp_class(rsp_class)
);

// File: tb/sim_reuse_class_table.sv
module sim_reuse_class_table;
  logic clk = 1'b0;
  logic rst_n;
  logic trn_valid, trn_reuse, qry_valid, rsp_ready;
  logic [31:0] trn_pc, qry_pc;
  logic trn_ready, qry_ready, rsp_valid;
  logic [7:0] rsp_cnt;
  logic [2:0] rsp_class;

  int n_chk = 0;
  int n_bad = 0;
  int mdl [512];
  bit exp_v;
  int exp_cnt;

  always #5 clk = ~clk;

  reuse_class_table u0 (
    .clk(clk), .rst_n(rst_n),
    .trn_valid(trn_valid), .trn_ready(trn_ready), .trn_pc(trn_pc), .trn_reuse(trn_reuse),
    .qry_valid(qry_valid), .qry_ready(qry_ready), .qry_pc(qry_pc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_cnt(rsp_cnt), .rsp_class(rsp_class)
  );

  function automatic int f_idx(logic [31:0] pc);
    return int'(pc[10:2] ^ pc[19:11]);
  endfunction

  function automatic int f_cls(int c);
    if (c < 32) return 0;
    if (c < 96) return 1;
    if (c < 160) return 2;
    if (c < 224) return 3;
    return 4;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // one cycle: drive at negedge, model the edge, check just after it
  task automatic step(bit qv, logic [31:0] qp, bit tv, logic [31:0] tp, bit tr, bit rr, string tag);
    bit take;
    @(negedge clk);
    qry_valid = qv; qry_pc = qp; trn_valid = tv; trn_pc = tp; trn_reuse = tr; rsp_ready = rr;
    #1;
    chk(qry_ready == (!exp_v || rr), "R7 qry_ready", int'(qry_ready), int'(!exp_v || rr));
    chk(trn_ready == 1'b1, "R9 trn_ready", int'(trn_ready), 1);
    take = qv && (!exp_v || rr);
    @(posedge clk);
    #1;
    if (take) begin
      exp_v = 1'b1;
      exp_cnt = mdl[f_idx(qp)];
    end else if (rr) begin
      exp_v = 1'b0;
    end
    if (tv) begin
      if (tr && mdl[f_idx(tp)] < 255) mdl[f_idx(tp)]++;
      if (!tr && mdl[f_idx(tp)] > 0) mdl[f_idx(tp)]--;
    end
    chk(rsp_valid == exp_v, "R6 rsp_valid", int'(rsp_valid), int'(exp_v));
    if (exp_v && rsp_valid) begin
      chk(int'(rsp_cnt) == exp_cnt, {tag, " R2 R3 count"}, int'(rsp_cnt), exp_cnt);
      chk(int'(rsp_class) == f_cls(exp_cnt), "R4 class", int'(rsp_class), f_cls(exp_cnt));
    end
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] pool [8];
    logic [31:0] p, alias_p;
    int seed;
    seed = 7;
    void'($urandom(seed));
    for (int i = 0; i < 512; i++) mdl[i] = 128;
    exp_v = 1'b0; exp_cnt = 0;
    rst_n = 1'b0; trn_valid = 0; qry_valid = 0; rsp_ready = 0;
    trn_pc = '0; qry_pc = '0; trn_reuse = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
    chk(qry_ready == 1'b1, "R1 qry_ready", int'(qry_ready), 1);
    for (int i = 0; i < 6; i++) step(1, $urandom, 0, 0, 0, 1, "R1");
    step(0, 0, 0, 0, 0, 1, "R1");

    // R8 + boundaries: query and train the same PC every cycle
    p = 32'h0004_5A3C;
    for (int i = 0; i < 140; i++) step(1, p, 1, p, 0, 1, "R8 R3");
    for (int i = 0; i < 300; i++) step(1, p, 1, p, 1, 1, "R8 R2");
    step(1, p, 0, 0, 0, 1, "R2 sat");
    chk(int'(rsp_cnt) == 255, "R2 saturate", int'(rsp_cnt), 255);

    // R5 aliasing: flip bit 2 and bit 11, same index
    alias_p = p ^ 32'h0000_0804;
    for (int i = 0; i < 260; i++) step(0, 0, 1, alias_p, 0, 1, "R5");
    step(1, p, 0, 0, 0, 1, "R5 alias");
    chk(int'(rsp_cnt) == 0, "R5 R3 alias floor", int'(rsp_cnt), 0);

    // R7 + R9: hold response under back-pressure while training continues
    step(1, alias_p, 0, 0, 0, 1, "R7");
    for (int i = 0; i < 5; i++) step(1, p, 1, p, 1, 0, "R7 R9");
    step(1, p, 0, 0, 0, 1, "R9");
    step(1, p, 0, 0, 0, 1, "R9 after");
    chk(int'(rsp_cnt) == 5, "R9 trained during stall", int'(rsp_cnt), 5);

    // random mix over a small PC pool with aliases
    for (int i = 0; i < 8; i++) pool[i] = $urandom;
    pool[1] = pool[0] ^ 32'h0000_1008;
    for (int i = 0; i < 6000; i++) begin
      step($urandom_range(0, 3) != 0, pool[$urandom_range(0, 7)],
           $urandom_range(0, 1) == 1, pool[$urandom_range(0, 7)],
           $urandom_range(0, 9) < ((i / 1500) % 2 == 0 ? 8 : 2),
           $urandom_range(0, 2) != 0, "rand");
    end
    step(0, 0, 0, 0, 0, 1, "drain");
    finish_run();
  end
endmodule